// File: doc/BRIEF.md
# Pulse Width and Period Meter

This block times a digital waveform against a slow base tick that is derived from the fast system clock. Software picks one of three sources, one of four measurement modes and a division factor for the base tick. The block then reports one of these values as a count of base ticks: the time the waveform spends high, the time it spends low, or the time from one rising edge to the next. A fourth mode returns two numbers for the same waveform. The first is the low time. The second is the fall-to-fall period.

The chosen source first passes through a synchroniser. It then passes through an optional qualifier that ignores pulses shorter than a fixed number of base ticks. Only after that does it reach the edge detector that drives a 16-bit saturating counter. Each latched result raises a completion flag that stays set until a clear pulse arrives. A count that saturates before the closing edge returns all ones and raises an overflow flag.

Top module: `pspan_meter`

## Requirements
- R1: After reset both results read 0 and the completion and overflow flags read 0.
- R2: With `meas_mode` = 0, `meas_res` receives the number of base ticks the filtered input was high. Counting starts at a rising edge and the value latches at the next falling edge.
- R3: With `meas_mode` = 1, `meas_res` receives the number of base ticks the filtered input was low. Counting starts at a falling edge and the value latches at the next rising edge.
- R4: With `meas_mode` = 2, every rising edge latches the rising-to-rising period into `meas_res` and restarts the count. The first rising edge after enabling only arms the measurement and latches nothing.
- R5: With `meas_mode` = 3, the rising edge that ends a low phase latches the low time into `meas_res`. The falling edge that follows latches the fall-to-fall period into `dual_per_res`, and `meas_res` keeps its value.
- R6: A base tick occurs once every (`base_div`+1)·DIV_MULT clock cycles, and all results count base ticks.
- R7: With `filt_en` = 1, a level that lasts fewer than FILT_LEN (3) base ticks is ignored and causes no latch. A level that lasts FILT_LEN ticks or more is measured with its full width.
- R8: The measured source follows `src_sel`: 0 selects `pin_a`, 1 selects `pin_b`, and 2 or 3 select `cmp_in`. Pulses on sources that are not selected cause no latch.
- R9: `done` is set in the cycle after each result latch. A one-cycle pulse on `done_clr` clears it, and a latch in the same cycle wins over the clear.
- R10: If the count reaches 2^16−1 before the closing edge, the result latches as 0xFFFF and `ovf` is set. `ovf_clr` clears `ovf`, and a later normal measurement leaves it clear.
- R11: While `meas_en` = 0 nothing latches and the results hold their values. An edge that closes a measurement but arrives before any opening edge since enabling latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_en | input | 1 | Measurement enable; low disarms the counter |
| meas_mode | input | 2 | 0 high time, 1 low time, 2 period, 3 low time plus period |
| base_div | input | DIV_W (3) | Base tick divider select |
| src_sel | input | 2 | Source select |
| filt_en | input | 1 | Short-pulse qualifier enable |
| pin_a | input | 1 | First pin source |
| pin_b | input | 1 | Second pin source |
| cmp_in | input | 1 | Comparator source |
| done_clr | input | 1 | Clears `done` (write-one pulse) |
| ovf_clr | input | 1 | Clears `ovf` (write-one pulse) |
| meas_res | output | CNT_W (16) | Main result |
| dual_per_res | output | CNT_W (16) | Period result of dual mode |
| done | output | 1 | Completion flag |
| ovf | output | 1 | Overflow flag |

## Verification
The hardest case to reach from the ports is saturation. The counter must run for 65535 base ticks before a closing edge arrives. The bench holds the input high for 70000 cycles at the fastest tick rate and then checks that the all-ones result and the overflow flag appear together. The second hardest case is a glitch inside a valid phase. A one-tick dip is driven in the middle of a high level with the qualifier on, and the bench expects one merged width. Every stimulus edge is placed on whole multiples of the tick period, so the expected counts are exact.

// File: rtl/pspan_pkg.sv
package pspan_pkg;

    typedef enum logic [1:0] {
        MEAS_HIGH   = 2'd0,
        MEAS_LOW    = 2'd1,
        MEAS_PERIOD = 2'd2,
        MEAS_DUAL   = 2'd3
    } meas_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic start;    // restart count and arm
        logic lat_main; // latch into main result
        logic lat_dual; // latch into dual period result
    } meas_ctl_t;

    function automatic logic pick_src(input logic [1:0] sel, input logic a,
                                      input logic b, input logic c);
        case (sel)
            2'd0:    return a;
            2'd1:    return b;
            default: return c;
        endcase
    endfunction

    function automatic meas_ctl_t decode_ctl(input meas_mode_e m, input edge_t e,
                                             input logic armed);
        meas_ctl_t c;
        c = '0;
        case (m)
            MEAS_HIGH: begin
                c.start    = e.rise;
                c.lat_main = e.fall & armed;
            end
            MEAS_LOW: begin
                c.start    = e.fall;
                c.lat_main = e.rise & armed;
            end
            MEAS_PERIOD: begin
                c.start    = e.rise;
                c.lat_main = e.rise & armed;
            end
            default: begin
                c.start    = e.fall;
                c.lat_dual = e.fall & armed;
                c.lat_main = e.rise & armed;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pspan_tick.sv
module pspan_tick #(
    parameter int DIV_W    = 3,
    parameter int DIV_MULT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel_i,
    output logic             tick_o
);
    localparam int MAX_FACT = (2 ** DIV_W) * DIV_MULT;
    localparam int TCW      = (MAX_FACT > 1) ? $clog2(MAX_FACT) : 1;

    logic [TCW-1:0] tcnt;
    logic [TCW-1:0] fact_m1;

    assign fact_m1 = TCW'((32'(div_sel_i) + 32'd1) * DIV_MULT - 32'd1);
    assign tick_o  = (tcnt >= fact_m1);

    always_ff @(posedge clk) begin
        if (rst)         tcnt <= '0;
        else if (tick_o) tcnt <= '0;
        else             tcnt <= tcnt + 1'b1;
    end

    // R6: with a factor above one, ticks never come back to back
    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_o && fact_m1 != '0) |=> (!tick_o || fact_m1 == '0));

endmodule

// File: rtl/pspan_filter.sv
module pspan_filter
    import pspan_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  filt_en_i,
    input  logic  raw_i,
    output edge_t edg_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic smp;
    logic flt;
    logic flt_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)    sync_q[i] <= 1'b0;
            else if (i == 0) sync_q[i] <= raw_i;
            else        sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
        end
    end
    assign smp = sync_q[SYNC_STAGES-1];

    if (FILT_LEN > 1) begin : g_qual
        localparam int SW = $clog2(FILT_LEN);
        logic [SW-1:0] stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                flt  <= 1'b0;
                stab <= '0;
            end else if (tick_i) begin
                if (!filt_en_i) begin
                    flt  <= smp;
                    stab <= '0;
                end else if (smp == flt) begin
                    stab <= '0;
                end else if (stab == SW'(FILT_LEN - 1)) begin
                    flt  <= smp;
                    stab <= '0;
                end else begin
                    stab <= stab + 1'b1;
                end
            end
        end
    end else begin : g_pass
        always_ff @(posedge clk) begin
            if (rst)         flt <= 1'b0;
            else if (tick_i) flt <= smp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         flt_q <= 1'b0;
        else if (tick_i) flt_q <= flt;
    end

    assign edg_o.rise = tick_i & flt & ~flt_q;
    assign edg_o.fall = tick_i & ~flt & flt_q;

    // R7: the qualified level only moves on a base tick
    p_filter_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(flt));

endmodule

// File: rtl/pspan_measure.sv
module pspan_measure
    import pspan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             tick_i,
    input  edge_t            edg_i,
    input  logic             done_clr_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] res_main_o,
    output logic [CNT_W-1:0] res_dual_o,
    output logic             done_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             armed;
    meas_ctl_t        ctl;
    logic             lat_any;
    logic             sat;

    assign ctl     = decode_ctl(meas_mode_e'(mode_i), edg_i, armed);
    assign lat_any = en_i & tick_i & (ctl.lat_main | ctl.lat_dual);
    assign sat     = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (tick_i) begin
            if (ctl.start) begin
                cnt   <= CNT_W'(1);
                armed <= 1'b1;
            end else if (armed && !sat) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_main_o <= '0;
            res_dual_o <= '0;
        end else if (en_i && tick_i) begin
            if (ctl.lat_main) res_main_o <= cnt;
            if (ctl.lat_dual) res_dual_o <= cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            if (lat_any)         done_o <= 1'b1;
            else if (done_clr_i) done_o <= 1'b0;
            if (lat_any && sat)  ovf_o  <= 1'b1;
            else if (ovf_clr_i)  ovf_o  <= 1'b0;
        end
    end

    // R9: a latch always leaves the completion flag set
    p_done_on_latch_r9: assert property (@(posedge clk) disable iff (rst)
        lat_any |=> done_o);

    // R10: overflow only appears together with an all-ones result
    p_ovf_result_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> (res_main_o == CNT_MAX || res_dual_o == CNT_MAX));

    // R10: the counter never wraps past all ones
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        sat |=> (cnt == CNT_MAX || cnt == CNT_W'(1) || cnt == '0));

    // R11: disabled means both results hold
    p_disabled_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(res_main_o) && $stable(res_dual_o)));

endmodule

// File: rtl/pspan_meter.sv
module pspan_meter
    import pspan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 3,
    parameter int DIV_MULT    = 1,
    parameter int FILT_LEN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_en,
    input  logic [1:0]       meas_mode,
    input  logic [DIV_W-1:0] base_div,
    input  logic [1:0]       src_sel,
    input  logic             filt_en,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             cmp_in,
    input  logic             done_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] meas_res,
    output logic [CNT_W-1:0] dual_per_res,
    output logic             done,
    output logic             ovf
);
    logic  tick;
    logic  raw;
    edge_t edg;

    assign raw = pick_src(src_sel, pin_a, pin_b, cmp_in);

    pspan_tick #(.DIV_W(DIV_W), .DIV_MULT(DIV_MULT)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .div_sel_i (base_div),
        .tick_o    (tick)
    );

    pspan_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .filt_en_i (filt_en),
        .raw_i     (raw),
        .edg_o     (edg)
    );

    pspan_measure #(.CNT_W(CNT_W)) u_measure (
        .clk        (clk),
        .rst        (rst),
        .en_i       (meas_en),
        .mode_i     (meas_mode),
        .tick_i     (tick),
        .edg_i      (edg),
        .done_clr_i (done_clr),
        .ovf_clr_i  (ovf_clr),
        .res_main_o (meas_res),
        .res_dual_o (dual_per_res),
        .done_o     (done),
        .ovf_o      (ovf)
    );

endmodule

// File: tb/pspan_meter_tb.sv
module pspan_meter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        meas_en = 1'b0;
    logic [1:0]  meas_mode = 2'd0;
    logic [2:0]  base_div = 3'd0;
    logic [1:0]  src_sel = 2'd0;
    logic        filt_en = 1'b0;
    logic        pin_a = 1'b0, pin_b = 1'b0, cmp_in = 1'b0;
    logic        done_clr = 1'b0, ovf_clr = 1'b0;
    logic [15:0] meas_res, dual_per_res;
    logic        done, ovf;

    int n_chk = 0;
    int n_bad = 0;
    int fact  = 1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pspan_meter dut_i (
        .clk(clk), .rst(rst), .meas_en(meas_en), .meas_mode(meas_mode),
        .base_div(base_div), .src_sel(src_sel), .filt_en(filt_en),
        .pin_a(pin_a), .pin_b(pin_b), .cmp_in(cmp_in),
        .done_clr(done_clr), .ovf_clr(ovf_clr),
        .meas_res(meas_res), .dual_per_res(dual_per_res), .done(done), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drv(input int idx, input logic v);
        case (idx)
            0: pin_a = v;
            1: pin_b = v;
            default: cmp_in = v;
        endcase
    endtask

    task automatic hold(input int ticks);
        repeat (ticks * fact) @(negedge clk);
    endtask

    task automatic clr_flags();
        done_clr = 1'b1; ovf_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic prep(input logic [1:0] m, input logic [2:0] dv, input logic [1:0] s,
                        input logic f, input logic lvl);
        meas_en = 1'b0;
        pin_a = 1'b0; pin_b = 1'b0; cmp_in = 1'b0;
        meas_mode = m; base_div = dv; src_sel = s; filt_en = f;
        fact = int'(dv) + 1;
        drv((s == 2'd3) ? 2 : int'(s), lvl);
        hold(20);
        clr_flags();
        meas_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 meas_res", meas_res, 0);
        chk("R1 dual_per_res", dual_per_res, 0);
        chk("R1 done", done, 0);
        chk("R1 ovf", ovf, 0);
    endtask

    task automatic t_high();
        prep(2'd0, 3'd0, 2'd0, 1'b0, 1'b0);
        hold(10); drv(0, 1); hold(25); drv(0, 0); hold(20);
        chk("R2 high 25", meas_res, 25);
        chk("R9 done set", done, 1);
        clr_flags();
        chk("R9 done cleared", done, 0);
        drv(0, 1); hold(7); drv(0, 0); hold(20);
        chk("R2 high 7", meas_res, 7);
    endtask

    task automatic t_low();
        prep(2'd1, 3'd0, 2'd0, 1'b0, 1'b1);
        hold(10); drv(0, 0); hold(13); drv(0, 1); hold(20);
        chk("R3 low 13", meas_res, 13);
        chk("R3 done", done, 1);
    endtask

    task automatic t_period();
        prep(2'd2, 3'd0, 2'd0, 1'b0, 1'b0);
        hold(5); drv(0, 1); hold(5); drv(0, 0); hold(12);
        chk("R4 first rise arms only", done, 0);
        drv(0, 1); hold(20);
        chk("R4 period 17", meas_res, 17);
        drv(0, 0); hold(9); drv(0, 1); hold(20);
        chk("R4 period 29", meas_res, 29);
    endtask

    task automatic t_dual();
        prep(2'd3, 3'd0, 2'd0, 1'b0, 1'b1);
        hold(5); drv(0, 0); hold(11);
        chk("R5 fall arms only", done, 0);
        drv(0, 1); hold(16);
        chk("R5 low 11", meas_res, 11);
        drv(0, 0); hold(20);
        chk("R5 period 27", dual_per_res, 27);
        chk("R5 main holds", meas_res, 11);
    endtask

    task automatic t_div();
        prep(2'd0, 3'd3, 2'd0, 1'b0, 1'b0);
        hold(5); drv(0, 1); hold(10); drv(0, 0); hold(20);
        chk("R6 div4 width", meas_res, 10);
        prep(2'd0, 3'd7, 2'd0, 1'b0, 1'b0);
        hold(5); drv(0, 1); hold(6); drv(0, 0); hold(20);
        chk("R6 div8 width", meas_res, 6);
    endtask

    task automatic t_filter();
        prep(2'd0, 3'd0, 2'd0, 1'b1, 1'b0);
        hold(5); drv(0, 1); hold(2); drv(0, 0); hold(20);
        chk("R7 short pulse no done", done, 0);
        chk("R7 short pulse result kept", meas_res, 6);
        drv(0, 1); hold(9); drv(0, 0); hold(20);
        chk("R7 long pulse", meas_res, 9);
        drv(0, 1); hold(10); drv(0, 0); hold(1); drv(0, 1); hold(10); drv(0, 0); hold(20);
        chk("R7 glitch merged", meas_res, 21);
    endtask

    task automatic t_source();
        prep(2'd0, 3'd0, 2'd1, 1'b0, 1'b0);
        hold(5); drv(0, 1); hold(12); drv(0, 0); hold(20);
        chk("R8 unselected pin_a ignored", done, 0);
        drv(1, 1); hold(8); drv(1, 0); hold(20);
        chk("R8 pin_b", meas_res, 8);
        prep(2'd0, 3'd0, 2'd2, 1'b0, 1'b0);
        hold(5); drv(2, 1); hold(14); drv(2, 0); hold(20);
        chk("R8 cmp_in code2", meas_res, 14);
        prep(2'd0, 3'd0, 2'd3, 1'b0, 1'b0);
        hold(5); drv(2, 1); hold(5); drv(2, 0); hold(20);
        chk("R8 cmp_in code3", meas_res, 5);
    endtask

    task automatic t_disable();
        prep(2'd0, 3'd0, 2'd0, 1'b0, 1'b0);
        meas_en = 1'b0;
        hold(5); drv(0, 1); hold(10); drv(0, 0); hold(20);
        chk("R11 disabled no done", done, 0);
        chk("R11 disabled result held", meas_res, 5);
        drv(0, 1); hold(20);
        meas_en = 1'b1;
        hold(5); drv(0, 0); hold(20);
        chk("R11 unarmed fall no latch", done, 0);
        drv(0, 1); hold(6); drv(0, 0); hold(20);
        chk("R11 after arming", meas_res, 6);
    endtask

    task automatic t_overflow();
        prep(2'd0, 3'd0, 2'd0, 1'b0, 1'b0);
        hold(5); drv(0, 1); hold(70000); drv(0, 0); hold(20);
        chk("R10 saturated result", meas_res, 16'hFFFF);
        chk("R10 ovf set", ovf, 1);
        clr_flags();
        chk("R10 ovf cleared", ovf, 0);
        drv(0, 1); hold(4); drv(0, 0); hold(20);
        chk("R10 normal after", meas_res, 4);
        chk("R10 ovf stays clear", ovf, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_high();
        t_low();
        t_period();
        t_dual();
        t_div();
        t_filter();
        t_source();
        t_disable();
        t_overflow();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule